// File: doc/BRIEF.md
# Speculative Load Fault Deferral Unit

This unit sits beside the load pipeline and settles, one operation per cycle, what happens when a speculative load meets an exceptional condition. It can raise the fault at once. It can also defer the fault: the memory reference is then suppressed and a not-a-thing (NaT) tag is placed on the destination register. The unit holds one NaT tag per architectural register. Ordinary arithmetic uses copy the tags of their sources into their results. A tagged register then becomes a branch to recovery code when a speculation check tests it, and a fault when it is consumed non-speculatively.

Three status inputs choose the deferral policy for a speculative load: interruption collection, translation enable, and a per-page early-deferral bit. A per-cause deferral mask and a spontaneous-deferral request (for example a cache miss) refine that choice in the most permissive policy. Each exception cause belongs to one of three classes, and two parameter masks assign the causes to those classes. Every operation gives a registered outcome (none, fault, defer or recovery branch) one cycle after it is presented. The same registered result also carries an encoded cause, a memory-suppress flag and a post-increment update enable.

Top module: `spec_defer_unit`

## Requirements
- R1: The policy is chosen from the status bits. Interruption collection 0 gives always-defer whatever the other bits are. Collection 1 with translation 0, or with translation 1 and the early-deferral bit 0, gives no-recovery. All three bits at 1 give recovery.
- R2: An exception whose cause is in the always-fault class faults in every policy. With default parameters this class is causes 1 and 2. A faulting load writes no tag, asserts no post-increment update, and reports its cause.
- R3: An exception whose cause is in the always-defer class defers in every policy. With default parameters this class is causes 3 and 4. A deferring load reports its cause.
- R4: Causes in neither class are mask-controlled (causes 0, 5, 6 and 7 by default). In always-defer they defer and in no-recovery they fault, whatever the mask holds. In recovery they defer when the cause's bit of the deferral mask is 1 and fault when it is 0.
- R5: A speculative load with no exception defers on a spontaneous request only in the recovery policy. In the other policies the request is ignored: the outcome is none and the destination tag is cleared.
- R6: A software suppression request on a speculative load with no exception defers it in every policy.
- R7: A deferral asserts memory-suppress, sets the destination tag, keeps the post-increment update enable equal to its request, and reports cause 0 when there was no exception.
- R8: A non-speculative load faults on any exception in every policy, reporting its cause. A non-speculative load without an exception and with an untagged base succeeds: its outcome is none and it clears the destination tag.
- R9: An arithmetic operation sets its destination tag to the OR of the tags of its two sources.
- R10: A check operation gives the recovery-branch outcome when its source is tagged and none otherwise. It changes no tag.
- R11: A non-speculative use of a tagged register faults with cause 0, and this covers a non-speculative load from a tagged base. A speculative load from a tagged base defers with cause 0. An always-fault exception takes priority over a tagged base.
- R12: Outcome encoding: 0 none, 1 fault, 2 defer, 3 recovery branch. It is registered one cycle after the operation. The cause output is 0 unless a fault or deferral came from an exception. After reset every tag is clear and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | 0 nop, 1 speculative load, 2 non-speculative load, 3 arithmetic, 4 check, 5 non-speculative use |
| dst_reg | input | 4 | Destination register index |
| src_a_reg | input | 4 | First source (load base, check operand) |
| src_b_reg | input | 4 | Second source |
| exc_valid | input | 1 | The load met an exceptional condition |
| exc_code | input | 3 | Cause of that condition |
| intr_collect | input | 1 | Interruption-collection status bit |
| xlat_en | input | 1 | Translation-enable status bit |
| page_early_defer | input | 1 | Early-deferral bit of the page being accessed |
| defer_mask | input | 8 | Per-cause deferral enables for the mask-controlled class |
| spont_req | input | 1 | Spontaneous deferral request |
| sw_suppress | input | 1 | Software request to suppress the speculative load |
| post_inc | input | 1 | The load also updates its base register |
| outcome | output | 2 | Registered outcome |
| cause_out | output | 3 | Registered cause |
| mem_suppress | output | 1 | The memory reference is suppressed |
| post_inc_upd | output | 1 | The base register update goes ahead |

## Verification
The main sweep drives speculative loads with every combination of the three status bits, every nonzero cause, the mask fully set and fully clear, and the spontaneous request on and off. Each load is followed by a check of its destination tag. The sweep separates the three policies and the three cause classes, and it shows that the mask and the spontaneous request have no effect outside recovery. A second sweep with no exception separates spontaneous deferral from software suppression across all status settings. Targeted patterns of source tags show OR propagation through arithmetic, recovery branching on checks, faults on non-speculative consumption, and the priority of an always-fault exception over a tagged base.

// File: rtl/defer_pkg.sv
// Shared types of the speculative load deferral unit.
// Assumes: operation and outcome codes are fixed at the top-level ports.
package defer_pkg;
    typedef enum logic [1:0] {
        MDL_ALWAYS = 2'd0,
        MDL_NOREC  = 2'd1,
        MDL_RECOV  = 2'd2
    } model_e;

    typedef enum logic [2:0] {
        OPK_NOP    = 3'd0,
        OPK_LDSPEC = 3'd1,
        OPK_LDNSPC = 3'd2,
        OPK_ALU    = 3'd3,
        OPK_CHECK  = 3'd4,
        OPK_USE    = 3'd5
    } opk_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_FAULT = 2'd1,
        RES_DEFER = 2'd2,
        RES_RECOV = 2'd3
    } res_e;
endpackage

// File: rtl/defer_model_sel.sv
// Picks the deferral policy from the status bits.
// Assumes: the bits are stable for the cycle of the load they apply to.
module defer_model_sel
    import defer_pkg::*;
(
    input  logic   intr_collect,
    input  logic   xlat_en,
    input  logic   page_early_defer,
    output model_e model
);
    // Collection off dominates; recovery needs all three bits set.
    always_comb begin
        if (!intr_collect)                  model = MDL_ALWAYS;
        else if (xlat_en && page_early_defer) model = MDL_RECOV;
        else                                model = MDL_NOREC;
    end
endmodule

// File: rtl/defer_decide.sv
// Fault-or-defer decision for a speculative load.
// Assumes: the class masks do not overlap; where they do, always-fault wins.
module defer_decide
    import defer_pkg::*;
#(
    parameter int CW = 3,
    parameter logic [(1<<CW)-1:0] FAULT_MASK = 8'b0000_0110,
    parameter logic [(1<<CW)-1:0] DEFER_MASK = 8'b0001_1000
) (
    input  model_e               model,
    input  logic                 exc_valid,
    input  logic [CW-1:0]        exc_code,
    input  logic [(1<<CW)-1:0]   defer_mask,
    input  logic                 spont_req,
    input  logic                 sw_suppress,
    input  logic                 base_nat,
    output logic                 do_fault,
    output logic                 do_defer
);
    logic cls_fault;
    logic cls_defer;

    // Classify the cause from the parameter masks.
    always_comb begin
        cls_fault = FAULT_MASK[exc_code];
        cls_defer = DEFER_MASK[exc_code] && !cls_fault;
    end

    // Apply the class and policy rules; without an exception only the
    // suppression, spontaneous and tagged-base paths can defer.
    always_comb begin
        do_fault = 1'b0;
        do_defer = 1'b0;
        if (exc_valid) begin
            if (cls_fault)      do_fault = 1'b1;
            else if (cls_defer) do_defer = 1'b1;
            else begin
                case (model)
                    MDL_ALWAYS: do_defer = 1'b1;
                    MDL_RECOV:  begin
                        do_defer = defer_mask[exc_code];
                        do_fault = !defer_mask[exc_code];
                    end
                    default:    do_fault = 1'b1;
                endcase
            end
        end else begin
            do_defer = sw_suppress || base_nat || (spont_req && model == MDL_RECOV);
        end
    end
endmodule

// File: rtl/defer_nat_file.sv
// One NaT tag per register, one write port and two read ports.
// Assumes: reads see the value from before this cycle's write.
module defer_nat_file #(
    parameter int NREG = 16,
    localparam int AW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wtag,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic          tag_a,
    output logic          tag_b
);
    logic [NREG-1:0] tags;

    for (genvar g = 0; g < NREG; g++) begin : g_tag
        // Hold, clear on reset, or take the written tag.
        always_ff @(posedge clk) begin
            if (!rst_n)                       tags[g] <= 1'b0;
            else if (we && waddr == AW'(g))   tags[g] <= wtag;
        end
    end

    assign tag_a = tags[ra];
    assign tag_b = tags[rb];
endmodule

// File: rtl/spec_defer_unit.sv
// Top of the deferral unit: decodes the operation, asks for the policy and
// the decision, updates the tag file and registers the outcome.
// Assumes: one operation per cycle; exc_code is meaningful only with exc_valid.
module spec_defer_unit
    import defer_pkg::*;
#(
    parameter int NREG = 16,
    parameter int CW   = 3,
    parameter logic [(1<<CW)-1:0] FAULT_MASK = 8'b0000_0110,
    parameter logic [(1<<CW)-1:0] DEFER_MASK = 8'b0001_1000,
    localparam int AW     = $clog2(NREG),
    localparam int NCAUSE = 1 << CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [AW-1:0]     dst_reg,
    input  logic [AW-1:0]     src_a_reg,
    input  logic [AW-1:0]     src_b_reg,
    input  logic              exc_valid,
    input  logic [CW-1:0]     exc_code,
    input  logic              intr_collect,
    input  logic              xlat_en,
    input  logic              page_early_defer,
    input  logic [NCAUSE-1:0] defer_mask,
    input  logic              spont_req,
    input  logic              sw_suppress,
    input  logic              post_inc,
    output logic [1:0]        outcome,
    output logic [CW-1:0]     cause_out,
    output logic              mem_suppress,
    output logic              post_inc_upd
);
    model_e        model;
    logic          do_fault, do_defer;
    logic          tag_a, tag_b;
    logic          we, wtag;
    res_e          res_n;
    logic [CW-1:0] cause_n;
    logic          supp_n, pinc_n;
    opk_e          kind;

    assign kind = opk_e'(op_kind);

    defer_model_sel u_model (
        .intr_collect    (intr_collect),
        .xlat_en         (xlat_en),
        .page_early_defer(page_early_defer),
        .model           (model)
    );

    defer_decide #(.CW(CW), .FAULT_MASK(FAULT_MASK), .DEFER_MASK(DEFER_MASK)) u_decide (
        .model      (model),
        .exc_valid  (exc_valid),
        .exc_code   (exc_code),
        .defer_mask (defer_mask),
        .spont_req  (spont_req),
        .sw_suppress(sw_suppress),
        .base_nat   (tag_a),
        .do_fault   (do_fault),
        .do_defer   (do_defer)
    );

    defer_nat_file #(.NREG(NREG)) u_nat (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .waddr(dst_reg),
        .wtag (wtag),
        .ra   (src_a_reg),
        .rb   (src_b_reg),
        .tag_a(tag_a),
        .tag_b(tag_b)
    );

    // Decode the operation into a tag write and the next outcome.
    always_comb begin
        res_n   = RES_NONE;
        cause_n = '0;
        supp_n  = 1'b0;
        pinc_n  = 1'b0;
        we      = 1'b0;
        wtag    = 1'b0;
        if (op_valid) begin
            case (kind)
                OPK_LDSPEC: begin
                    if (do_fault) begin
                        res_n   = RES_FAULT;
                        cause_n = exc_valid ? exc_code : '0;
                        supp_n  = 1'b1;
                    end else begin
                        pinc_n = post_inc;
                        we     = 1'b1;
                        wtag   = do_defer;
                        if (do_defer) begin
                            res_n   = RES_DEFER;
                            cause_n = exc_valid ? exc_code : '0;
                            supp_n  = 1'b1;
                        end
                    end
                end
                OPK_LDNSPC: begin
                    if (exc_valid) begin
                        res_n   = RES_FAULT;
                        cause_n = exc_code;
                        supp_n  = 1'b1;
                    end else if (tag_a) begin
                        res_n  = RES_FAULT;
                        supp_n = 1'b1;
                    end else begin
                        pinc_n = post_inc;
                        we     = 1'b1;
                    end
                end
                OPK_ALU: begin
                    we   = 1'b1;
                    wtag = tag_a | tag_b;
                end
                OPK_CHECK: begin
                    if (tag_a) res_n = RES_RECOV;
                end
                OPK_USE: begin
                    if (tag_a || tag_b) res_n = RES_FAULT;
                end
                default: ;
            endcase
        end
    end

    // Register the outcome fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outcome      <= RES_NONE;
            cause_out    <= '0;
            mem_suppress <= 1'b0;
            post_inc_upd <= 1'b0;
        end else begin
            outcome      <= res_n;
            cause_out    <= cause_n;
            mem_suppress <= supp_n;
            post_inc_upd <= pinc_n;
        end
    end

    logic spec_ld;
    assign spec_ld = op_valid && op_kind == 3'd1;

    assert_alwaysdefer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spec_ld && exc_valid && !intr_collect && !FAULT_MASK[exc_code]
        |=> outcome == 2'd2);

    assert_faultcls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spec_ld && exc_valid && FAULT_MASK[exc_code]
        |=> outcome == 2'd1 && !post_inc_upd);

    assert_defercls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spec_ld && exc_valid && DEFER_MASK[exc_code] && !FAULT_MASK[exc_code]
        |=> outcome == 2'd2 && cause_out == $past(exc_code));

    assert_spont_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spec_ld && !exc_valid && !sw_suppress && !tag_a && spont_req
        && !(intr_collect && xlat_en && page_early_defer)
        |=> outcome == 2'd0);

    assert_defer_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
        outcome == 2'd2 |-> mem_suppress);

    assert_nspec_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == 3'd2 && exc_valid
        |=> outcome == 2'd1 && cause_out == $past(exc_code));

    assert_check_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == 3'd4 |=> outcome == 2'd0 || outcome == 2'd3);
endmodule

// File: tb/sim_spec_defer_unit.sv
module sim_spec_defer_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [2:0] op_kind;
    logic [3:0] dst_reg, src_a_reg, src_b_reg;
    logic       exc_valid;
    logic [2:0] exc_code;
    logic       intr_collect, xlat_en, page_early_defer;
    logic [7:0] defer_mask;
    logic       spont_req, sw_suppress, post_inc;
    logic [1:0] outcome;
    logic [2:0] cause_out;
    logic       mem_suppress, post_inc_upd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    spec_defer_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .dst_reg(dst_reg), .src_a_reg(src_a_reg), .src_b_reg(src_b_reg),
        .exc_valid(exc_valid), .exc_code(exc_code), .intr_collect(intr_collect),
        .xlat_en(xlat_en), .page_early_defer(page_early_defer), .defer_mask(defer_mask),
        .spont_req(spont_req), .sw_suppress(sw_suppress), .post_inc(post_inc),
        .outcome(outcome), .cause_out(cause_out), .mem_suppress(mem_suppress),
        .post_inc_upd(post_inc_upd)
    );

    // Drive one operation at a falling edge; return at the next falling edge.
    task automatic op(input int kind, input int d, input int a, input int b,
                      input bit ev, input int code, input bit pi, input bit ss, input bit sp);
        op_valid    = (kind != 0);
        op_kind     = 3'(kind);
        dst_reg     = 4'(d);
        src_a_reg   = 4'(a);
        src_b_reg   = 4'(b);
        exc_valid   = ev;
        exc_code    = 3'(code);
        post_inc    = pi;
        sw_suppress = ss;
        spont_req   = sp;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input int er, input int ec,
                              input bit es, input bit ep);
        checks++;
        if (outcome !== 2'(er) || cause_out !== 3'(ec)
            || mem_suppress !== es || post_inc_upd !== ep) begin
            errors++;
            $display("FAIL %s: outcome %0d cause %0d supp %0d pinc %0d, expected %0d %0d %0d %0d",
                     req, outcome, cause_out, mem_suppress, post_inc_upd, er, ec, es, ep);
        end
    endtask

    task automatic tag_check(input string req, input int r, input bit exp_tag);
        op(4, 0, r, 0, 0, 0, 0, 0, 0);
        expect_out(req, exp_tag ? 3 : 0, 0, 0, 0);
    endtask

    // Force a register tag: suppression sets it, a clean plain load clears it.
    task automatic set_tag(input int r, input bit v);
        if (v) op(1, r, 1, 0, 0, 0, 0, 1, 0);
        else   op(2, r, 1, 0, 0, 0, 0, 0, 0);
    endtask

    // Reference policy: 0 always-defer, 1 no-recovery, 2 recovery.
    function automatic int ref_model(bit ic, bit it, bit ed);
        if (!ic) return 0;
        if (it && ed) return 2;
        return 1;
    endfunction

    // Reference outcome of a speculative load with an exception.
    function automatic int ref_exc(int mdl, int code, bit mk);
        if (code == 1 || code == 2) return 1;
        if (code == 3 || code == 4) return 2;
        if (mdl == 0) return 2;
        if (mdl == 1) return 1;
        return mk ? 2 : 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op_valid = 0; op_kind = 0; dst_reg = 0; src_a_reg = 0; src_b_reg = 0;
        exc_valid = 0; exc_code = 0; intr_collect = 1; xlat_en = 1;
        page_early_defer = 1; defer_mask = 0; spont_req = 0; sw_suppress = 0; post_inc = 0;
        repeat (3) @(negedge clk);
        // R12: reset state of the outputs and of every tag
        expect_out("R12 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        for (int r = 0; r < 16; r++) tag_check("R12 reset tag", r, 0);

        // R8: clean plain load succeeds and keeps the post-increment
        op(2, 1, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 clean load", 0, 0, 0, 1);

        // R1 R2 R3 R4 R5 R7: full sweep of status bits, causes, mask, spontaneous
        for (int m = 0; m < 8; m++) begin
            for (int code = 1; code < 8; code++) begin
                for (int mk = 0; mk < 2; mk++) begin
                    for (int sp = 0; sp < 2; sp++) begin
                        int mdl, er;
                        intr_collect = m[2]; xlat_en = m[1]; page_early_defer = m[0];
                        defer_mask = mk[0] ? 8'hFF : 8'h00;
                        mdl = ref_model(m[2], m[1], m[0]);
                        er = ref_exc(mdl, code, mk[0]);
                        set_tag(2, 0);
                        op(1, 2, 1, 0, 1, code, 1, 0, sp[0]);
                        expect_out("R1 R2 R3 R4 sweep", er, code, 1, er == 2);
                        tag_check("R7 sweep tag", 2, er == 2);
                    end
                end
            end
        end

        // R5 R6: no exception, spontaneous and software suppression
        for (int m = 0; m < 8; m++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int ss = 0; ss < 2; ss++) begin
                    bit dfr;
                    intr_collect = m[2]; xlat_en = m[1]; page_early_defer = m[0];
                    dfr = ss[0] || (sp[0] && ref_model(m[2], m[1], m[0]) == 2);
                    set_tag(2, 1);
                    op(1, 2, 1, 0, 0, 0, 1, ss[0], sp[0]);
                    expect_out("R5 R6 no exception", dfr ? 2 : 0, 0, dfr, 1);
                    tag_check("R5 R6 tag", 2, dfr);
                end
            end
        end

        // R11: tagged base on speculative and plain loads, fault priority
        intr_collect = 1; xlat_en = 0; page_early_defer = 0;
        set_tag(3, 1);
        set_tag(2, 0);
        op(1, 2, 3, 0, 0, 0, 0, 0, 0);
        expect_out("R11 spec tagged base", 2, 0, 1, 0);
        tag_check("R11 propagated tag", 2, 1);
        op(1, 2, 3, 0, 1, 1, 1, 0, 0);
        expect_out("R11 fault priority", 1, 1, 1, 0);
        op(2, 5, 3, 0, 0, 0, 1, 0, 0);
        expect_out("R11 plain load tagged base", 1, 0, 1, 0);

        // R8: plain load exceptions fault in every policy, tag untouched
        for (int m = 0; m < 8; m++) begin
            intr_collect = m[2]; xlat_en = m[1]; page_early_defer = m[0];
            set_tag(2, 1);
            op(2, 2, 1, 0, 1, 3 + (m % 5), 1, 0, 0);
            expect_out("R8 plain load fault", 1, 3 + (m % 5), 1, 0);
            tag_check("R8 tag kept", 2, 1);
        end

        // R9 R10 R11: propagation, checks, non-speculative uses
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                set_tag(4, a[0]);
                set_tag(5, b[0]);
                set_tag(6, !(a[0] || b[0]));
                op(3, 6, 4, 5, 0, 0, 0, 0, 0);
                expect_out("R9 arithmetic outcome", 0, 0, 0, 0);
                tag_check("R9 OR of tags", 6, a[0] || b[0]);
                tag_check("R10 check", 4, a[0]);
                op(5, 0, 4, 5, 0, 0, 0, 0, 0);
                expect_out("R11 use", (a[0] || b[0]) ? 1 : 0, 0, 0, 0);
            end
        end

        // R12: idle cycle reports nothing
        op(0, 0, 0, 0, 1, 5, 1, 1, 1);
        expect_out("R12 idle", 0, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule